// File: doc/BRIEF.md
# Line Parity Stream Splitter

This block sits in a pixel pipeline and takes one image stream with a valid/ready handshake. Each beat carries a data word, an end-of-line flag and an end-of-frame flag. In split mode the block sends whole lines to two outputs by their position in the frame. The first line of every frame and every other line after it go to output A. The lines in between go to output B. Each output has a small FIFO in front of it, so a consumer can stall for a few cycles without holding up the other output.

In merge mode the block uses only output A. It stores an odd line in a line memory, sends it out, and then passes the next even line straight through after it. Together the two lines form one line of twice the width. The block never drops a beat. When the output it needs is full, it lowers its input ready instead. The mode input may change only while reset is held.

Top module: `lnpar_split`

## Requirements
- R1: After reset, a_valid and b_valid are low and in_ready is high.
- R2: In split mode, lines 1, 3, 5, ... of a frame leave on output A and lines 2, 4, 6, ... leave on output B. Data, eol and eof are unchanged and the beat order within each output is kept.
- R3: A beat that carries eof resets the line count, so the next line goes to output A.
- R4: In split mode, the eof beat leaves on the output that owns that line, with eol set. The other output gets one marker beat with eof=1, eol=0 and data all zeros, placed after its earlier beats.
- R5: No beat is lost or duplicated when an output stalls. While the FIFO the current beat needs is full, in_ready is low.
- R6: While an output has valid high and ready low, its valid, data, eol and eof do not change at the next cycle.
- R7: In merge mode, an odd line and the even line after it leave on output A as one line: first the odd beats, then the even beats. Only the last even beat carries eol. Output B never goes valid.
- R8: In merge mode, when the odd line's last beat also carries eof, that line leaves alone on output A, with eol and eof set on its last beat. Lines may be up to MAXW beats long.
- R9: In merge mode, the eof of a paired even line appears on the last beat of the joined output line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| merge_mode | input | 1 | 0 = split by line parity, 1 = join line pairs on A |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | DW | Input data word |
| in_eol | input | 1 | Last beat of a line |
| in_eof | input | 1 | Last beat of a frame (set together with in_eol) |
| a_valid | output | 1 | Output A valid |
| a_ready | input | 1 | Output A ready |
| a_data | output | DW | Output A data |
| a_eol | output | 1 | Output A end of line |
| a_eof | output | 1 | Output A end of frame |
| b_valid | output | 1 | Output B valid |
| b_ready | input | 1 | Output B ready |
| b_data | output | DW | Output B data |
| b_eol | output | 1 | Output B end of line |
| b_eof | output | 1 | Output B end of frame |

## Verification
The hardest case to reach is back-pressure that spreads from one output to the input. This happens when one consumer stalls while the other keeps draining, and it is worst on an eof beat, which needs room in both FIFOs. To reach it, the bench holds one ready low, toggles the other with a pseudo-random pattern, and sends frames longer than the FIFO depth. It checks that in_ready was seen low and that every queued beat still came out in order. For merge mode, the bench uses lines of exactly MAXW beats and frames with an odd line count. These exercise the full line memory and the lone trailing line.

// File: rtl/lnpar_pkg.sv
package lnpar_pkg;
  typedef enum logic [1:0] {
    MG_FILL  = 2'd0,
    MG_DRAIN = 2'd1,
    MG_EVEN  = 2'd2
  } mg_state_e;
endpackage

// File: rtl/lnpar_fifo.sv
module lnpar_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push, pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push    = wr_en && !full;
  assign pop     = rd_en && !empty;
  assign rd_data = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
    if (pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    if (push && !pop) cnt_d = cnt_q + CW'(1);
    else if (pop && !push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wr_data;
  end
endmodule

// File: rtl/lnpar_linebuf.sv
module lnpar_linebuf #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lnpar_split.sv
module lnpar_split
  import lnpar_pkg::*;
#(
  parameter int DW     = 8,
  parameter int MAXW   = 16,
  parameter int FDEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          merge_mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_eol,
  input  logic          in_eof,
  output logic          a_valid,
  input  logic          a_ready,
  output logic [DW-1:0] a_data,
  output logic          a_eol,
  output logic          a_eof,
  output logic          b_valid,
  input  logic          b_ready,
  output logic [DW-1:0] b_data,
  output logic          b_eol,
  output logic          b_eof
);
  localparam int AW = $clog2(MAXW);
  localparam int LW = $clog2(MAXW + 1);
  localparam int BW = DW + 2;

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  mg_state_e     state_q, state_d;
  logic          par_q, par_d;
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LW-1:0] len_q, len_d;
  logic          lone_q, lone_d;

  logic          fa_push, fa_full, fa_empty;
  logic          fb_push, fb_full, fb_empty;
  logic [BW-1:0] fa_din, fb_din, fa_dout, fb_dout;
  logic          buf_we;
  logic [DW-1:0] buf_rd;
  logic [BW-1:0] beat, marker;
  logic          drain_last;

  assign beat       = {in_eof, in_eol, in_data};
  assign marker     = {1'b1, 1'b0, {DW{1'b0}}};
  assign drain_last = (rptr_q == AW'(len_q - LW'(1)));

  always_comb begin
    state_d  = state_q;
    par_d    = par_q;
    wptr_d   = wptr_q;
    rptr_d   = rptr_q;
    len_d    = len_q;
    lone_d   = lone_q;
    in_ready = 1'b0;
    fa_push  = 1'b0;
    fb_push  = 1'b0;
    fa_din   = beat;
    fb_din   = beat;
    buf_we   = 1'b0;
    if (!merge_mode) begin
      state_d = MG_FILL;
      if (!par_q) begin
        in_ready = !fa_full && (!in_eof || !fb_full);
        fa_push  = in_valid && in_ready;
        fb_push  = fa_push && in_eof;
        fb_din   = marker;
      end else begin
        in_ready = !fb_full && (!in_eof || !fa_full);
        fb_push  = in_valid && in_ready;
        fa_push  = fb_push && in_eof;
        fa_din   = marker;
      end
      if (in_valid && in_ready) begin
        if (in_eof)      par_d = 1'b0;
        else if (in_eol) par_d = ~par_q;
      end
    end else begin
      par_d = 1'b0;
      case (state_q)
        MG_FILL: begin
          in_ready = 1'b1;
          buf_we   = in_valid;
          if (in_valid) begin
            wptr_d = wptr_q + AW'(1);
            if (in_eol) begin
              len_d   = LW'(wptr_q) + LW'(1);
              wptr_d  = '0;
              rptr_d  = '0;
              lone_d  = in_eof;
              state_d = MG_DRAIN;
            end
          end
        end
        MG_DRAIN: begin
          fa_din  = {lone_q && drain_last, lone_q && drain_last, buf_rd};
          fa_push = !fa_full;
          if (fa_push) begin
            rptr_d = rptr_q + AW'(1);
            if (drain_last) state_d = lone_q ? MG_FILL : MG_EVEN;
          end
        end
        MG_EVEN: begin
          in_ready = !fa_full;
          fa_push  = in_valid && in_ready;
          if (fa_push && in_eol) state_d = MG_FILL;
        end
        default: state_d = MG_FILL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= MG_FILL;
      par_q   <= 1'b0;
      wptr_q  <= '0;
      rptr_q  <= '0;
      len_q   <= '0;
      lone_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      par_q   <= par_d;
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      len_q   <= len_d;
      lone_q  <= lone_d;
    end
  end

  lnpar_linebuf #(.DW(DW), .DEPTH(MAXW)) u_line (
    .clk   (clk),
    .we    (buf_we),
    .waddr (wptr_q),
    .wdata (in_data),
    .raddr (rptr_q),
    .rdata (buf_rd)
  );

  lnpar_fifo #(.W(BW), .DEPTH(FDEPTH)) u_fifo_a (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (fa_push),
    .wr_data (fa_din),
    .full    (fa_full),
    .rd_en   (a_ready),
    .rd_data (fa_dout),
    .empty   (fa_empty)
  );

  lnpar_fifo #(.W(BW), .DEPTH(FDEPTH)) u_fifo_b (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (fb_push),
    .wr_data (fb_din),
    .full    (fb_full),
    .rd_en   (b_ready),
    .rd_data (fb_dout),
    .empty   (fb_empty)
  );

  assign a_valid = !fa_empty;
  assign {a_eof, a_eol, a_data} = fa_dout;
  assign b_valid = !fb_empty;
  assign {b_eof, b_eol, b_data} = fb_dout;
endmodule

// File: rtl/lnpar_split_chk.sv
module lnpar_split_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          merge_mode,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_eof,
  input logic          par_q,
  input logic          a_valid,
  input logic          a_ready,
  input logic [DW-1:0] a_data,
  input logic          a_eol,
  input logic          a_eof,
  input logic          b_valid,
  input logic          b_ready,
  input logic [DW-1:0] b_data,
  input logic          b_eol,
  input logic          b_eof
);
  AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && !a_ready |=> a_valid && $stable({a_eof, a_eol, a_data})); // R6

  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid && !b_ready |=> b_valid && $stable({b_eof, b_eol, b_data})); // R6

  AST_MERGE_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    merge_mode |-> !b_valid); // R7

  AST_PARITY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !merge_mode && in_valid && in_ready && in_eof |=> !par_q); // R3

  AST_MARKER_A: assert property (@(posedge clk) disable iff (!rst_n)
    !merge_mode && a_valid && a_eof && !a_eol |-> a_data == '0); // R4

  AST_MARKER_B: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid && b_eof && !b_eol |-> b_data == '0); // R4
endmodule

bind lnpar_split lnpar_split_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .merge_mode (merge_mode),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_eof     (in_eof),
  .par_q      (par_q),
  .a_valid    (a_valid),
  .a_ready    (a_ready),
  .a_data     (a_data),
  .a_eol      (a_eol),
  .a_eof      (a_eof),
  .b_valid    (b_valid),
  .b_ready    (b_ready),
  .b_data     (b_data),
  .b_eol      (b_eol),
  .b_eof      (b_eof)
);

// File: tb/tb_lnpar_split.sv
module tb_lnpar_split;
  localparam int DW = 8;
  localparam int MAXW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic merge_mode;
  logic in_valid, in_ready, in_eol, in_eof;
  logic [DW-1:0] in_data;
  logic a_valid, a_ready, a_eol, a_eof;
  logic b_valid, b_ready, b_eol, b_eof;
  logic [DW-1:0] a_data, b_data;

  int n_chk = 0;
  int n_bad = 0;
  int stall_seen = 0;
  int b_seen = 0;
  int cyc = 0;
  int rmode_a = 0;
  int rmode_b = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [DW+1:0] qa[$], qb[$];
  string ta[$], tb[$];
  logic a_pend = 1'b0, b_pend = 1'b0;
  logic [DW+1:0] a_hv, b_hv;

  lnpar_split #(.DW(DW), .MAXW(MAXW), .FDEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .merge_mode(merge_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_eol(in_eol), .in_eof(in_eof),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data), .a_eol(a_eol), .a_eof(a_eof),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data), .b_eol(b_eol), .b_eof(b_eof)
  );

  always #10 clk = ~clk;

  function automatic void chk(string r, logic [DW+1:0] got, logic [DW+1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", r, got, exp);
    end
  endfunction

  always @(posedge clk) begin
    lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    a_ready <= (rmode_a == 0) ? 1'b1 : (rmode_a == 1) ? lfsr[0] : 1'b0;
    b_ready <= (rmode_b == 0) ? 1'b1 : (rmode_b == 1) ? lfsr[3] : 1'b0;
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
    if (!rst_n) begin
      a_pend = 1'b0; b_pend = 1'b0;
    end else begin
      if (a_pend && a_valid) chk("R6 a hold", {a_eof, a_eol, a_data}, a_hv);
      if (b_pend && b_valid) chk("R6 b hold", {b_eof, b_eol, b_data}, b_hv);
      a_pend = a_valid && !a_ready; a_hv = {a_eof, a_eol, a_data};
      b_pend = b_valid && !b_ready; b_hv = {b_eof, b_eol, b_data};
      if (merge_mode && b_valid) b_seen++;
      if (a_valid && a_ready) begin
        if (qa.size() == 0) chk("R5 extra beat on A", {a_eof, a_eol, a_data}, 'x);
        else chk(ta.pop_front(), {a_eof, a_eol, a_data}, qa.pop_front());
      end
      if (b_valid && b_ready) begin
        if (qb.size() == 0) chk("R5 extra beat on B", {b_eof, b_eol, b_data}, 'x);
        else chk(tb.pop_front(), {b_eof, b_eol, b_data}, qb.pop_front());
      end
    end
  end

  task automatic put(input logic [DW-1:0] d, input logic eol, input logic eof);
    in_valid = 1'b1; in_data = d; in_eol = eol; in_eof = eof;
    forever begin
      #1;
      if (in_ready) break;
      stall_seen++;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [DW-1:0] pix(int base, int l, int i);
    return DW'(base + l * 16 + i);
  endfunction

  task automatic push_exp(bit to_b, logic [DW+1:0] v, string t);
    if (to_b) begin qb.push_back(v); tb.push_back(t); end
    else begin qa.push_back(v); ta.push_back(t); end
  endtask

  task automatic send_frame(int nl, int len, int base);
    for (int l = 0; l < nl; l++)
      for (int i = 0; i < len; i++)
        put(pix(base, l, i), i == len - 1, (i == len - 1) && (l == nl - 1));
  endtask

  task automatic exp_split(int nl, int len, int base, string t);
    for (int l = 0; l < nl; l++)
      for (int i = 0; i < len; i++) begin
        logic eol = (i == len - 1);
        logic eof = eol && (l == nl - 1);
        push_exp(l % 2 == 1, {eof, eol, pix(base, l, i)}, eof ? "R4 eof" : t);
      end
    push_exp((nl - 1) % 2 == 0, {1'b1, 1'b0, {DW{1'b0}}}, "R4 marker");
  endtask

  task automatic exp_merge(int nl, int len, int base);
    for (int l = 0; l < nl; l++)
      for (int i = 0; i < len; i++) begin
        logic last_line = (l == nl - 1);
        logic eol;
        if (l % 2 == 0 && last_line) begin
          eol = (i == len - 1);
          push_exp(1'b0, {eol, eol, pix(base, l, i)}, "R8 lone");
        end else if (l % 2 == 0) begin
          push_exp(1'b0, {2'b00, pix(base, l, i)}, "R7 odd part");
        end else begin
          eol = (i == len - 1);
          push_exp(1'b0, {eol && last_line, eol, pix(base, l, i)},
                   (eol && last_line) ? "R9 eof" : "R7 even part");
        end
      end
  endtask

  task automatic drain(string t);
    int w = 0;
    while ((qa.size() != 0 || qb.size() != 0) && w < 5000) begin
      @(negedge clk); w++;
    end
    repeat (3) @(negedge clk);
    chk(t, 10'(qa.size() + qb.size()), 10'd0);
  endtask

  task automatic do_reset(logic m);
    rst_n = 1'b0; merge_mode = m; in_valid = 1'b0;
    in_data = '0; in_eol = 1'b0; in_eof = 1'b0;
    rmode_a = 0; rmode_b = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    chk("R1 reset a_valid", 10'(a_valid), 10'd0);
    chk("R1 reset b_valid", 10'(b_valid), 10'd0);
    chk("R1 reset in_ready", 10'(in_ready), 10'd1);
  endtask

  task automatic t_split_basic;
    exp_split(4, 5, 8'h10, "R2 split");
    send_frame(4, 5, 8'h10);
    drain("R2 all delivered");
  endtask

  task automatic t_split_parity;
    exp_split(3, 4, 8'h40, "R2 split");
    exp_split(2, 3, 8'h80, "R3 new frame");
    send_frame(3, 4, 8'h40);
    send_frame(2, 3, 8'h80);
    drain("R3 all delivered");
  endtask

  task automatic t_split_backpressure;
    stall_seen = 0;
    rmode_a = 1; rmode_b = 2;
    exp_split(6, 7, 8'h20, "R5 stalled");
    fork
      send_frame(6, 7, 8'h20);
      begin repeat (60) @(negedge clk); rmode_b = 1; end
    join
    drain("R5 all delivered");
    chk("R5 in_ready dropped", 10'(stall_seen > 0), 10'd1);
    rmode_a = 0; rmode_b = 0;
  endtask

  task automatic t_merge_pair;
    do_reset(1'b1);
    b_seen = 0;
    exp_merge(4, 4, 8'h30);
    send_frame(4, 4, 8'h30);
    drain("R7 all delivered");
    chk("R7 B quiet", 10'(b_seen), 10'd0);
  endtask

  task automatic t_merge_odd;
    rmode_a = 1;
    exp_merge(3, 3, 8'h60);
    send_frame(3, 3, 8'h60);
    drain("R8 all delivered");
    rmode_a = 0;
  endtask

  task automatic t_merge_full;
    b_seen = 0;
    exp_merge(1, MAXW, 8'h00);
    send_frame(1, MAXW, 8'h00);
    exp_merge(2, MAXW, 8'h90);
    send_frame(2, MAXW, 8'h90);
    drain("R8 full width delivered");
    chk("R7 B quiet full", 10'(b_seen), 10'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    merge_mode = 1'b0;
    in_valid = 1'b0; in_data = '0; in_eol = 1'b0; in_eof = 1'b0;
    a_ready = 1'b1; b_ready = 1'b1;
    t_reset();
    t_split_basic();
    t_split_parity();
    t_split_backpressure();
    t_merge_pair();
    t_merge_odd();
    t_merge_full();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule